// File: doc/BRIEF.md
# Modulo Real-Time Counter with Prescaler

This block is a 16-bit periodic counter for timekeeping. Three tick-enable strobes, all synchronous to the system clock, are its possible time bases. A select field picks one of them, or none. The chosen strobe passes through a programmable pre-divider whose ratios include both decimal and power-of-two steps. Each divided tick advances the counter.

The counter runs up to a limit held in a shadow register. Software never writes the shadow register directly. It writes a modulo register, and that value is copied into the shadow only when the counter wraps or when a software restart is applied. When the count matches the limit on a divided tick, the counter returns to zero, emits a one-clock overflow pulse and latches a pending flag. The pending flag and an enable bit together drive a single interrupt line. Software clears the flag by reading a vector register.

Software reaches the block through a small bus with an address, a write strobe, a read strobe and 16-bit data. Each read returns its data one cycle after the read strobe.

Top module: `rtc_modulo_counter`

## Requirements
- R1: After reset the control word reads 0x0000, the count reads 0, the modulo register reads 0xFFFF (parameter MOD_INIT), the vector reads 0, and irq_o and ovf_o are 0.
- R2: Control bits 13:12 select the time base. The value 0 stops all counting. The values 1, 2 and 3 count tick_i[0], tick_i[1] and tick_i[2] respectively, and the unselected strobes have no effect on the count.
- R3: Control bits 10:8 set the pre-divider. The codes 0,1,2,3,4,5,6,7 divide by 1,10,100,1000,16,64,256,1024. The count advances exactly once for each such number of selected ticks.
- R4: On a divided tick with the count equal to the shadow limit, the count becomes 0, ovf_o is high for exactly one clock, and the pending flag (control bit 0) is set. The flag and ovf_o rise in the same cycle.
- R5: A write to the modulo register does not change the running limit. The new value is taken into the shadow register only at the next wrap or at an applied software restart.
- R6: irq_o is high exactly while the pending flag is set and the enable bit (control bit 1) is 1.
- R7: The vector register reads 0x0002 while the flag is pending and 0x0000 otherwise. A read that returns 0x0002 clears the flag. A read that returns 0x0000 changes nothing.
- R8: If an overflow occurs in the same cycle as a vector read, the flag remains set after that read.
- R9: Writing 1 to control bit 6 arms a restart. On the next tick of the selected source, the count becomes 0 and the shadow is loaded from the modulo register, with no overflow pulse and no flag. Bit 6 always reads 0, and writing 0 to it has no effect.
- R10: Any write that changes the source or divider field restarts the pre-divider from zero. An armed software restart also restarts the pre-divider when it is applied.
- R11: Control bits 15:14, 11, 7 and 5:2 read 0 and ignore writes. Control bit 0 cannot be written.
- R12: The address map is 0 control, 1 count (read-only), 2 modulo, 3 vector. rdata_o carries the addressed value in the cycle after rd_en_i and is 0 in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 3 | Tick-enable strobes of the three time bases |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| irq_o | output | 1 | Interrupt request |
| ovf_o | output | 1 | One-clock overflow pulse |

## Verification
A pre-divider count that is wrong or restarted at the wrong time shows up as a count readback that is off by one after exactly N source ticks. The bench therefore probes each ratio at N-1 ticks and at N ticks. A shadow limit that is wrong shows up as an overflow pulse on the wrong tick, or as a count that runs past the programmed modulo. This is visible on ovf_o in the cycle after the deciding tick. A flag that is wrong appears on irq_o and on the vector readback in the very next cycle, including the case where a read and an overflow collide.

// File: rtl/rtcm_pkg.sv
// Package: shared widths, register addresses, control bit positions and the
// pre-divider ratio decode for the modulo real-time counter.
package rtcm_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;
    localparam int PS_W    = 3;
    localparam int PDIV_W  = 10;   // wide enough for the largest ratio minus one

    typedef enum logic [1:0] {
        ADR_CTRL  = 2'd0,
        ADR_COUNT = 2'd1,
        ADR_MOD   = 2'd2,
        ADR_VEC   = 2'd3
    } reg_addr_e;

    // Control word bit positions
    localparam int CB_FLAG  = 0;
    localparam int CB_IE    = 1;
    localparam int CB_SWRST = 6;
    localparam int CB_PS_LO = 8;
    localparam int CB_SS_LO = 12;

    localparam logic [DATA_W-1:0] VEC_PENDING = 16'h0002;

    // Ratio decode: the four low codes are decimal steps, the four high codes binary
    function automatic int unsigned div_ratio(input logic [PS_W-1:0] enc);
        int unsigned r;
        case (enc)
            3'd0:    r = 1;
            3'd1:    r = 10;
            3'd2:    r = 100;
            3'd3:    r = 1000;
            3'd4:    r = 16;
            3'd5:    r = 64;
            3'd6:    r = 256;
            default: r = 1024;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtcm_prescaler.sv
// Module: rtcm_prescaler
// Picks one tick strobe (or none) by the source field and divides it by the
// ratio that the divider field selects. The output pulse marks the last source
// tick of each group of N. A restart request zeroes the group count and
// suppresses any output in that cycle.
// Assumes: all strobes are synchronous single-cycle enables in the clk domain.
module rtcm_prescaler
    import rtcm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   src_sel_i,
    input  logic [PS_W-1:0]    div_sel_i,
    input  logic               restart_i,
    output logic               src_tick_o,
    output logic               div_tick_o
);

    logic [NUM_SRC-1:0] src_hit;
    logic [PDIV_W-1:0]  pcnt_q;
    logic [PDIV_W-1:0]  lim;

    // One-hot decode of the source field; code 0 selects nothing
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = (src_sel_i == SEL_W'(g + 1));
    end

    // Selected strobe and terminal value of the group counter
    always_comb begin
        src_tick_o = |(tick_i & src_hit);
        lim        = PDIV_W'(div_ratio(div_sel_i) - 1);
        div_tick_o = src_tick_o && !restart_i && (pcnt_q == lim);
    end

    // Group counter: restart dominates, otherwise count selected ticks modulo N
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (restart_i) begin
            pcnt_q <= '0;
        end else if (src_tick_o) begin
            if (pcnt_q == lim) pcnt_q <= '0;
            else               pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_DIV_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick_o |-> src_tick_o);                                    // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pcnt_q == '0));                                 // R10

endmodule

// File: rtl/rtcm_counter.sv
// Module: rtcm_counter
// Main count and shadow limit. A divided tick advances the count or wraps it
// at the limit. A wrap reloads the shadow and flags an overflow. An armed
// software restart waits for the next source tick, then zeroes the count and
// reloads the shadow without any overflow.
// Assumes: div_tick_i is already suppressed in the cycle a restart applies.
module rtcm_counter
    import rtcm_pkg::*;
#(
    parameter logic [DATA_W-1:0] MOD_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick_i,
    input  logic              div_tick_i,
    input  logic              sr_req_i,
    input  logic [DATA_W-1:0] modulo_i,
    output logic              sr_apply_o,
    output logic              ovf_evt_o,
    output logic              ovf_o,
    output logic [DATA_W-1:0] count_o
);

    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] shadow_q;
    logic              sr_pend_q;
    logic              ovf_q;

    // Restart applies on the first source tick after it was armed
    always_comb begin
        sr_apply_o = sr_pend_q && src_tick_i;
        ovf_evt_o  = div_tick_i && !sr_apply_o && (count_q == shadow_q);
        ovf_o      = ovf_q;
        count_o    = count_q;
    end

    // Arm on a restart write, disarm once it has taken effect
    always_ff @(posedge clk) begin
        if (!rst_n)          sr_pend_q <= 1'b0;
        else if (sr_req_i)   sr_pend_q <= 1'b1;
        else if (sr_apply_o) sr_pend_q <= 1'b0;
    end

    // Count, wrap and shadow reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            shadow_q <= MOD_INIT;
        end else if (sr_apply_o) begin
            count_q  <= '0;
            shadow_q <= modulo_i;
        end else if (ovf_evt_o) begin
            count_q  <= '0;
            shadow_q <= modulo_i;
        end else if (div_tick_i) begin
            count_q  <= count_q + 1'b1;
        end
    end

    // One-clock overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_evt_o;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (count_q == '0));                                    // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= shadow_q);                                          // R5
    AST_SR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sr_apply_o |=> (!ovf_q && count_q == '0));                     // R9

endmodule

// File: rtl/rtcm_regs.sv
// Module: rtcm_regs
// Register file: the control word, the modulo register, the pending flag and
// the registered read port. A vector read clears the flag, except when an
// overflow lands in the same cycle.
// Assumes: one access per cycle; a read answers in the following cycle.
module rtcm_regs
    import rtcm_pkg::*;
#(
    parameter logic [DATA_W-1:0] MOD_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ovf_evt_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              flag_o,
    output logic              ie_o,
    output logic [SEL_W-1:0]  src_sel_o,
    output logic [PS_W-1:0]   div_sel_o,
    output logic [DATA_W-1:0] modulo_o,
    output logic              cfg_chg_o,
    output logic              sr_req_o
);

    logic              ie_q;
    logic [SEL_W-1:0]  ss_q;
    logic [PS_W-1:0]   ps_q;
    logic              flag_q;
    logic [DATA_W-1:0] mod_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_ctrl;
    logic              wr_mod;
    logic              vec_rd;
    logic [SEL_W-1:0]  new_ss;
    logic [PS_W-1:0]   new_ps;
    logic [DATA_W-1:0] ctrl_rd;

    // Access decode and control-word readback assembly
    always_comb begin
        wr_ctrl   = wr_en_i && (addr_i == ADR_CTRL);
        wr_mod    = wr_en_i && (addr_i == ADR_MOD);
        vec_rd    = rd_en_i && (addr_i == ADR_VEC);
        new_ss    = wdata_i[CB_SS_LO +: SEL_W];
        new_ps    = wdata_i[CB_PS_LO +: PS_W];
        cfg_chg_o = wr_ctrl && ((new_ss != ss_q) || (new_ps != ps_q));
        sr_req_o  = wr_ctrl && wdata_i[CB_SWRST];
        ctrl_rd                      = '0;
        ctrl_rd[CB_FLAG]             = flag_q;
        ctrl_rd[CB_IE]               = ie_q;
        ctrl_rd[CB_PS_LO +: PS_W]    = ps_q;
        ctrl_rd[CB_SS_LO +: SEL_W]   = ss_q;
    end

    // Writable control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
            ss_q <= '0;
            ps_q <= '0;
        end else if (wr_ctrl) begin
            ie_q <= wdata_i[CB_IE];
            ss_q <= new_ss;
            ps_q <= new_ps;
        end
    end

    // Modulo register
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= MOD_INIT;
        else if (wr_mod) mod_q <= wdata_i;
    end

    // Pending flag: an overflow sets it and wins over a clearing vector read
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (ovf_evt_i)          flag_q <= 1'b1;
        else if (vec_rd && flag_q)   flag_q <= 1'b0;
    end

    // Registered read port; zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            case (addr_i)
                ADR_CTRL:  rdata_q <= ctrl_rd;
                ADR_COUNT: rdata_q <= count_i;
                ADR_MOD:   rdata_q <= mod_q;
                default:   rdata_q <= flag_q ? VEC_PENDING : '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign rdata_o   = rdata_q;
    assign flag_o    = flag_q;
    assign ie_o      = ie_q;
    assign src_sel_o = ss_q;
    assign div_sel_o = ps_q;
    assign modulo_o  = mod_q;

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_i |=> flag_q);                                         // R4
    AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && flag_q && !ovf_evt_i) |=> !flag_q);                 // R7
    AST_OVF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && ovf_evt_i) |=> flag_q);                             // R8
    AST_SWRST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADR_CTRL) |=> !rdata_q[CB_SWRST]);       // R9

endmodule

// File: rtl/rtc_modulo_counter.sv
// Module: rtc_modulo_counter (top)
// Joins the register file, the source pre-divider and the modulo counter.
// It also forms the interrupt from the pending flag and the enable bit.
// Assumes: a single synchronous clock domain; tick inputs are enables.
module rtc_modulo_counter
    import rtcm_pkg::*;
#(
    parameter logic [15:0] MOD_INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  tick_i,
    input  logic [1:0]  addr_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        irq_o,
    output logic        ovf_o
);

    logic              flag;
    logic              ie;
    logic [SEL_W-1:0]  src_sel;
    logic [PS_W-1:0]   div_sel;
    logic [DATA_W-1:0] modulo;
    logic [DATA_W-1:0] count;
    logic              cfg_chg;
    logic              sr_req;
    logic              sr_apply;
    logic              src_tick;
    logic              div_tick;
    logic              ovf_evt;
    logic              pre_restart;

    rtcm_regs #(.MOD_INIT(MOD_INIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .wdata_i   (wdata_i),
        .ovf_evt_i (ovf_evt),
        .count_i   (count),
        .rdata_o   (rdata_o),
        .flag_o    (flag),
        .ie_o      (ie),
        .src_sel_o (src_sel),
        .div_sel_o (div_sel),
        .modulo_o  (modulo),
        .cfg_chg_o (cfg_chg),
        .sr_req_o  (sr_req)
    );

    // Pre-divider restarts on a field change or an applied software restart
    assign pre_restart = cfg_chg || sr_apply;

    rtcm_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .src_sel_i  (src_sel),
        .div_sel_i  (div_sel),
        .restart_i  (pre_restart),
        .src_tick_o (src_tick),
        .div_tick_o (div_tick)
    );

    rtcm_counter #(.MOD_INIT(MOD_INIT)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_i (src_tick),
        .div_tick_i (div_tick),
        .sr_req_i   (sr_req),
        .modulo_i   (modulo),
        .sr_apply_o (sr_apply),
        .ovf_evt_o  (ovf_evt),
        .ovf_o      (ovf_o),
        .count_o    (count)
    );

    // Interrupt line: pending and enabled
    assign irq_o = flag && ie;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ie) |-> !irq_o);                                    // R6
    AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == '0) |-> !div_tick);                                // R2

endmodule

// File: tb/tb_rtc_modulo_counter.sv
// Scoreboard bench: register reads push expected words into a queue, and a
// monitor pops and compares them when the registered data appears. Pin
// checks are made directly between clock edges.
module tb_rtc_modulo_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tick = '0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;

    always #5 clk = ~clk;

    rtc_modulo_counter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq),
        .ovf_o   (ovf)
    );

    // Independent ratio table from the divider requirement
    function automatic int ratio_of(input int enc);
        case (enc)
            0: return 1;    1: return 10;   2: return 100;  3: return 1000;
            4: return 16;   5: return 64;   6: return 256;  default: return 1024;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Marks the edge that latches a read
    always @(posedge clk) rd_d <= rd_en;

    // Monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R12: read with empty scoreboard actual=0x%0h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tick[idx] = 1'b1;
            @(posedge clk); #1;
            tick[idx] = 1'b0;
        end
    endtask

    initial begin
        int ec;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 ovf", ovf, 0);
        rd(0, 16'h0000, "R1 ctrl");
        rd(1, 16'h0000, "R1 count");
        rd(2, 16'hFFFF, "R1 modulo");
        rd(3, 16'h0000, "R1 vector");
        @(posedge clk); #1;
        check("R12 idle rdata", rdata, 0);

        // R2 disabled source
        pulse(0, 2); pulse(1, 2); pulse(2, 2);
        rd(1, 16'h0000, "R2 disabled count");

        // R2/R5: source 0, divide by 1, modulo written but not yet active
        wr(2, 16'h0003);
        wr(0, 16'h1002);
        pulse(1, 3); pulse(2, 3);
        rd(1, 16'h0000, "R2 unselected ticks");
        pulse(0, 4);
        check("R5 no early wrap", ovf, 0);
        pulse(0, 1);
        rd(1, 16'h0005, "R5 count past new modulo");

        // R9 software restart
        wr(0, 16'h1042);
        rd(0, 16'h1002, "R9 reads zero");
        pulse(0, 1);
        check("R9 no ovf", ovf, 0);
        check("R9 no irq", irq, 0);
        rd(1, 16'h0000, "R9 count cleared");

        // R4 wrap at the loaded limit
        pulse(0, 3);
        rd(1, 16'h0003, "R4 count at limit");
        pulse(0, 1);
        check("R4 ovf pulse", ovf, 1);
        check("R6 irq on", irq, 1);
        @(posedge clk); #1;
        check("R4 ovf one clock", ovf, 0);
        rd(1, 16'h0000, "R4 wrapped count");
        rd(0, 16'h1003, "R4 flag set");

        // R7 vector read clears
        rd(3, 16'h0002, "R7 vector pending");
        rd(0, 16'h1002, "R7 flag cleared");
        check("R7 irq off", irq, 0);
        rd(3, 16'h0000, "R7 vector idle");

        // R6 enable gating, R11 reserved bits
        wr(0, 16'h1000);
        pulse(0, 4);
        check("R6 ovf with ie off", ovf, 1);
        check("R6 irq masked", irq, 0);
        rd(0, 16'h1001, "R6 flag still set");
        wr(0, 16'hD8BE);
        check("R6 irq after enable", irq, 1);
        rd(0, 16'h1003, "R11 reserved bits ignored");

        // R8 overflow colliding with a vector read
        pulse(0, 3);
        @(posedge clk); #1;
        tick[0] = 1'b1; addr = 2'd3; rd_en = 1'b1;
        exp_q.push_back(16'h0002); tag_q.push_back("R8 collide read");
        @(posedge clk); #1;
        tick[0] = 1'b0; rd_en = 1'b0;
        rd(0, 16'h1003, "R8 flag kept");
        rd(3, 16'h0002, "R8 vector again");
        rd(0, 16'h1002, "R8 flag cleared");

        // R3 all divider codes on source 2
        wr(2, 16'hFFFF);
        wr(0, 16'h3040);
        pulse(2, 1);
        rd(1, 16'h0000, "R9 restart on source 2");
        ec = 0;
        for (int enc = 0; enc < 8; enc++) begin
            wr(0, 16'h3000 | 16'(enc << 8));
            pulse(2, ratio_of(enc) - 1);
            rd(1, 16'(ec), $sformatf("R3 code %0d before", enc));
            pulse(2, 1);
            ec++;
            rd(1, 16'(ec), $sformatf("R3 code %0d after", enc));
        end

        // R10 restart on source change and on divider change
        wr(0, 16'h3200);
        pulse(2, 40);
        wr(0, 16'h2200);
        pulse(1, 99);
        rd(1, 16'(ec), "R10 source change restart before");
        pulse(1, 1);
        ec++;
        rd(1, 16'(ec), "R10 source change restart after");
        pulse(1, 30);
        wr(0, 16'h2100);
        pulse(1, 9);
        rd(1, 16'(ec), "R10 divider change restart before");
        pulse(1, 1);
        ec++;
        rd(1, 16'(ec), "R10 divider change restart after");

        @(posedge clk); @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule